// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block turns a binary input code into the switch-control words of a segmented current-steering DAC. The upper field of the code is expanded into a thermometer word that drives a row of equal-weight unit cells. The lower field passes through unchanged and drives a set of binary-weighted cells. A third output is a one-hot pointer to the lowest unit cell that is still off. That cell is the one whose current feeds the binary sub-array, which keeps the output monotonic where the two segments meet.

All three words leave the block from one shared register. Every switch therefore changes on the same clock edge, one cycle after the code is presented with its valid strobe. When the strobe is low, the register keeps its contents. The field widths are parameters, and the defaults are 4 upper bits and 4 lower bits. With the defaults the block drives 15 unit cells and 4 binary cells, which is 19 switch controls in total.

Top module: `seg_dac_decoder`

## Requirements
- R1: For an upper-field value k, `unit_on` has exactly k ones in bit positions 0 through k-1, and every higher bit is zero.
- R2: `bin_on` equals the lower `LSB_BITS` bits of the sampled code. Bit i of `bin_on` drives the cell of weight 2^i.
- R3: `spare_sel` is one-hot over 2^`MSB_BITS` positions, with bit k set for upper-field value k. When all unit cells are on, bit 2^`MSB_BITS`-1 is set, and that position stands for no real cell.
- R4: The set bit of `spare_sel` sits at the index equal to the number of ones in `unit_on`, which is the lowest unit cell that is off.
- R5: When `code_valid` is low at a rising edge, all outputs keep their previous values.
- R6: When `rst_n` is low at a rising edge, `unit_on` and `bin_on` clear to zero and `spare_sel` becomes 1 (position 0).
- R7: A code sampled with `code_valid` high appears on all outputs together after exactly one rising edge.
- R8: The number of ones in `unit_on` times 2^`LSB_BITS`, plus `bin_on`, equals the sampled code.
- R9: If a new code has an upper field at least as large as the current one, no unit cell that is on turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| code_valid | input | 1 | Loads `code_in` at the next rising edge |
| code_in | input | MSB_BITS+LSB_BITS | Binary DAC code |
| unit_on | output | 2^MSB_BITS-1 | Thermometer controls for the unit cells |
| bin_on | output | LSB_BITS | Controls for the binary-weighted cells |
| spare_sel | output | 2^MSB_BITS | One-hot select of the lowest unit cell that is off |

## Verification
The bench applies every code in ascending order. This shows whether the thermometer fills from the bottom with the right count, whether the pointer follows the count, and whether any unit cell drops out when the upper field goes up. A descending pass catches cells that fail to release. Two edge cases get their own checks: the all-zero code, where the pointer must sit at position 0, and the all-ones code, where the pointer must move to the dummy top position. A hold test keeps `code_valid` low while `code_in` changes and confirms that the outputs do not move. A reset issued mid-run must return the outputs to their cleared state.

// File: rtl/seg_dac_pkg.sv
// Package: default segment widths shared by the decoder and its bench.
// Assumes: nothing; constants only.
package seg_dac_pkg;
    localparam int DEF_MSB_BITS = 4;
    localparam int DEF_LSB_BITS = 4;
endpackage

// File: rtl/seg_therm_decode.sv
// Module: binary-to-thermometer expansion of the upper code field.
// Assumes: IN_W >= 1; output bit i is high when the level exceeds i.
module seg_therm_decode #(
    parameter int IN_W = 4,
    localparam int OUT_W = (1 << IN_W) - 1
) (
    input  logic [IN_W-1:0]  level,
    output logic [OUT_W-1:0] therm
);
    // one comparator per unit cell
    for (genvar g = 0; g < OUT_W; g++) begin : g_cell
        localparam logic [IN_W-1:0] POS = IN_W'(g);
        assign therm[g] = (level > POS);
    end
endmodule

// File: rtl/seg_spare_pointer.sv
// Module: one-hot pointer to the lowest unit cell that is off.
// Assumes: position 2^IN_W-1 is a dummy that is used only when all cells are on.
module seg_spare_pointer #(
    parameter int IN_W = 4,
    localparam int OUT_W = 1 << IN_W
) (
    input  logic [IN_W-1:0]  level,
    output logic [OUT_W-1:0] onehot
);
    // one equality decode per position
    for (genvar g = 0; g < OUT_W; g++) begin : g_pos
        localparam logic [IN_W-1:0] POS = IN_W'(g);
        assign onehot[g] = (level == POS);
    end
endmodule

// File: rtl/seg_switch_reg.sv
// Module: shared retiming register for all switch controls.
// Assumes: synchronous active-low reset to RST_VAL; loads only when 'load' is high.
module seg_switch_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // single edge for every switch; hold when not loading
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= RST_VAL;
        else if (load) q <= d;
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n)) |=> $stable(q));
endmodule

// File: rtl/seg_dac_decoder.sv
// Module: segmented DAC switch decoder top.
// Splits the code into a thermometer-decoded upper field and a pass-through
// lower field, adds a pointer to the lowest unit cell that is off, and
// retimes everything in one register.
// Assumes: MSB_BITS >= 1, LSB_BITS >= 1.
module seg_dac_decoder
    import seg_dac_pkg::*;
#(
    parameter int MSB_BITS = DEF_MSB_BITS,
    parameter int LSB_BITS = DEF_LSB_BITS,
    localparam int CODE_W = MSB_BITS + LSB_BITS,
    localparam int UNITS  = (1 << MSB_BITS) - 1,
    localparam int PTR_W  = 1 << MSB_BITS,
    localparam int REG_W  = PTR_W + UNITS + LSB_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_in,
    output logic [UNITS-1:0]  unit_on,
    output logic [LSB_BITS-1:0] bin_on,
    output logic [PTR_W-1:0]  spare_sel
);
    localparam logic [REG_W-1:0] RST_WORD = REG_W'(1) << (UNITS + LSB_BITS);

    logic [MSB_BITS-1:0] msb_field;
    logic [LSB_BITS-1:0] lsb_field;
    logic [UNITS-1:0]    therm_d;
    logic [PTR_W-1:0]    ptr_d;
    logic [REG_W-1:0]    word_q;

    // split the code into its two segments
    assign msb_field = code_in[CODE_W-1:LSB_BITS];
    assign lsb_field = code_in[LSB_BITS-1:0];

    seg_therm_decode #(.IN_W(MSB_BITS)) u_therm (
        .level (msb_field),
        .therm (therm_d)
    );

    seg_spare_pointer #(.IN_W(MSB_BITS)) u_ptr (
        .level  (msb_field),
        .onehot (ptr_d)
    );

    seg_switch_reg #(.W(REG_W), .RST_VAL(RST_WORD)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (code_valid),
        .d     ({ptr_d, therm_d, lsb_field}),
        .q     (word_q)
    );

    // unpack the register into the three output words
    assign bin_on    = word_q[LSB_BITS-1:0];
    assign unit_on   = word_q[UNITS+LSB_BITS-1:LSB_BITS];
    assign spare_sel = word_q[REG_W-1:UNITS+LSB_BITS];

    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(spare_sel) == 1);

    assert_pointer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spare_sel[$countones(unit_on)] == 1'b1);

    assert_reset_R6: assert property (@(posedge clk)
        !rst_n |=> (unit_on == '0 && bin_on == '0 && spare_sel == PTR_W'(1)));

    assert_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && $past(rst_n)) |=>
        (($countones(unit_on) * (1 << LSB_BITS) + int'(bin_on)) == int'($past(code_in))));

    assert_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && $past(rst_n) && int'(msb_field) >= $countones(unit_on)) |=>
        ((unit_on & $past(unit_on)) == $past(unit_on)));
endmodule

// File: tb/seg_dac_decoder_test.sv
// Bench: directed scenarios for the segmented DAC switch decoder.
module seg_dac_decoder_test;
    localparam int MB = 4;
    localparam int LB = 4;
    localparam int CW = MB + LB;
    localparam int NU = (1 << MB) - 1;
    localparam int NP = 1 << MB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic code_valid = 1'b0;
    logic [CW-1:0] code_in = '0;
    logic [NU-1:0] unit_on;
    logic [LB-1:0] bin_on;
    logic [NP-1:0] spare_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    seg_dac_decoder #(.MSB_BITS(MB), .LSB_BITS(LB)) uut (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_in(code_in),
        .unit_on(unit_on), .bin_on(bin_on), .spare_sel(spare_sel)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // reference: k ones filled upward
    function automatic logic [NU-1:0] ref_therm(input int k);
        logic [NU-1:0] t = '0;
        for (int i = 0; i < NU; i++) t[i] = (i < k);
        return t;
    endfunction

    // apply one code with valid and check every output after the next edge
    task automatic apply_check(input int code, input logic [NU-1:0] prev_units, input bit rising);
        int k;
        int ones;
        k = code >> LB;
        @(negedge clk);
        code_in = CW'(code);
        code_valid = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 thermometer", 64'(unit_on), 64'(ref_therm(k)));
        chk("R2 binary field", 64'(bin_on), 64'(code % (1 << LB)));
        chk("R3 pointer", 64'(spare_sel), 64'(1) << k);
        ones = $countones(unit_on);
        chk("R4 pointer at first off cell", 64'(spare_sel[ones]), 64'd1);
        chk("R8 weighted sum", 64'(ones * (1 << LB) + int'(bin_on)), 64'(code));
        if (rising)
            chk("R9 no cell released", 64'(unit_on & prev_units), 64'(prev_units));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        code_valid = 1'b1;
        code_in = '1;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R6 reset unit_on", 64'(unit_on), 64'd0);
        chk("R6 reset bin_on", 64'(bin_on), 64'd0);
        chk("R6 reset spare_sel", 64'(spare_sel), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        code_valid = 1'b0;
    endtask

    task automatic t_ascending();
        logic [NU-1:0] prev = '0;
        for (int c = 0; c < (1 << CW); c++) begin
            apply_check(c, prev, 1'b1);
            prev = unit_on;
        end
    endtask

    task automatic t_descending();
        for (int c = (1 << CW) - 1; c >= 0; c -= 7)
            apply_check(c, '0, 1'b0);
    endtask

    task automatic t_corners();
        apply_check(0, '0, 1'b0);
        chk("R3 zero code pointer at 0", 64'(spare_sel), 64'd1);
        apply_check((1 << CW) - 1, '0, 1'b0);
        chk("R3 full code uses dummy top position", 64'(spare_sel), 64'(1) << (NP - 1));
        chk("R1 all unit cells on", 64'(unit_on), 64'({NU{1'b1}}));
    endtask

    task automatic t_latency();
        apply_check(8'h25, '0, 1'b0);
        @(negedge clk);
        code_in = 8'hB3;
        code_valid = 1'b1;
        #1;
        chk("R7 no change before edge", 64'(bin_on), 64'h5);
        @(posedge clk);
        #1;
        chk("R7 units after one edge", 64'(unit_on), 64'(ref_therm(11)));
        chk("R7 binary after same edge", 64'(bin_on), 64'h3);
        chk("R7 pointer after same edge", 64'(spare_sel), 64'(1) << 11);
    endtask

    task automatic t_hold();
        apply_check(8'h6A, '0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            code_valid = 1'b0;
            code_in = CW'(8'hF1 - i * 13);
            @(posedge clk);
            #1;
            chk("R5 hold unit_on", 64'(unit_on), 64'(ref_therm(6)));
            chk("R5 hold bin_on", 64'(bin_on), 64'hA);
            chk("R5 hold spare_sel", 64'(spare_sel), 64'(1) << 6);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ascending();
        t_descending();
        t_corners();
        t_latency();
        t_hold();
        apply_check(8'h9C, '0, 1'b0);
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule